// File: doc/BRIEF.md
# Link Training Reset Delay Controller

This block is a control slice that sits beside a serial link controller and decides when the link training state machine may run. When software has turned on the delay feature, a hot reset or link-down reset that arrives after the link has come up keeps the training enable low once core reset lets go. The enable stays low until software writes an explicit completion command. In that window software can reprogram configuration state with no race against the link coming back up. At first bring-up, before the link has ever come up, training starts without waiting.

Software reaches the block over a simple single-cycle register port with address, write data, write strobe and combinational read data. A control register takes half-word-masked writes: bits 31:16 of the write data choose which of bits 15:0 change. A two-bit event status register is write-one-to-clear. A mask register sits at the next word and gates the status bits onto one interrupt line.

Top module: `link_hold_ctrl`

## Requirements
- R1: After reset the control, status and mask registers read zero, `irq` is 0 and `train_en` equals `core_rst_n`.
- R2: A write to byte offset 0x180 changes control bit i (i in 0..15) only when write-data bit 16+i is 1. Bit i then takes write-data bit i, and every other bit keeps its value. The register reads back on the low half-word with the upper half zero.
- R3: Control bit 3 is the delay-done command. It reads back as 0 at all times.
- R4: While `core_rst_n` is low, `train_en` is 0.
- R5: Control bit 4 turns on block-driven training enable, and bit 1 turns on the delay. With both set and the link up at least once, a `reset_evt` pulse holds `train_en` at 0 from the next cycle on, including after `core_rst_n` rises. A masked write of bit 3 as 1 releases the hold, and `train_en` returns to 1 the cycle after that write.
- R6: A delay-done write when no hold is pending has no effect: `train_en` stays 1.
- R7: A `reset_evt` that arrives before any `link_up_chg` pulse creates no hold.
- R8: With control bit 4 clear, `train_en` follows `core_rst_n`. With bit 1 clear, a `reset_evt` creates no hold.
- R9: `reset_evt` sets status bit 0 and `link_up_chg` sets status bit 1. The status register sits at byte offset 0x10, and each bit is set in the cycle after its event.
- R10: Writing ones to the status register clears those bits. A set in the same cycle wins over the clear.
- R11: The mask register sits at byte offset 0x14, bits 1:0. `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R12: A read from any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| core_rst_n | input | 1 | Active-low controller core reset |
| reset_evt | input | 1 | One-cycle pulse on a hot reset or link-down reset |
| link_up_chg | input | 1 | One-cycle pulse on a link-up state change |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| train_en | output | 1 | Link training enable |
| irq | output | 1 | Masked event interrupt |

## Verification
The hard case is a hold that is really pending. To reach it, the controller must be in block-driven mode with the delay turned on, a link-up change must already have been seen, and only then can a reset event arrive, all before the done command. Directed sequences build this state step by step, release core reset while it is held, and then fire both a useful and a redundant done command. A long random phase then mixes events, core reset and masked writes at rates high enough to re-enter the hold many times. Every cycle of that phase is compared against a bench model.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  localparam int unsigned CTRL_W      = 16;
  localparam int unsigned BIT_DLY_EN  = 1;
  localparam int unsigned BIT_DONE    = 3;
  localparam int unsigned BIT_ENH     = 4;
  localparam int unsigned EVT_N       = 2;
  localparam int unsigned EVT_RST     = 0;
  localparam int unsigned EVT_LINK    = 1;

  typedef enum logic {
    HOLD_RUN  = 1'b0,
    HOLD_WAIT = 1'b1
  } hold_state_e;
endpackage

// File: rtl/lhc_ctrl_reg.sv
module lhc_ctrl_reg
  import lhc_pkg::*;
#(
  parameter int unsigned W = CTRL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   ctrl_q,
  output logic           done_pulse
);
  logic [W-1:0] ctrl_d;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    if (gi == BIT_DONE) begin : g_pulse
      assign ctrl_d[gi] = 1'b0;
    end else begin : g_store
      assign ctrl_d[gi] = (wr_en && wdata[W+gi]) ? wdata[gi] : ctrl_q[gi];
    end
  end

  assign done_pulse = wr_en && wdata[W+BIT_DONE] && wdata[BIT_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R2: an unselected bit keeps its value across a write
  a_r2_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[W+BIT_ENH]) |=> $stable(ctrl_q[BIT_ENH]));
  a_r2_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[W+BIT_DLY_EN]) |=> (ctrl_q[BIT_DLY_EN] == $past(wdata[BIT_DLY_EN])));
  a_r3_done_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !ctrl_q[BIT_DONE]);
endmodule

// File: rtl/lhc_irq.sv
module lhc_irq
  import lhc_pkg::*;
#(
  parameter int unsigned N = EVT_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] status_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] status_d;
  logic [N-1:0] mask_d;

  always_comb begin
    status_d = status_q;
    if (clr_we) status_d = status_d & ~clr_bits;
    status_d = status_d | evt_set;
    mask_d   = mask_we ? mask_bits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign irq = |(status_q & mask_q);

  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[EVT_RST] |=> status_q[EVT_RST]);
  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[EVT_LINK] && !evt_set[EVT_LINK]) |=> !status_q[EVT_LINK]);
  a_r11_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: rtl/lhc_hold_fsm.sv
module lhc_hold_fsm
  import lhc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enh_mode,
  input  logic dly_en,
  input  logic reset_evt,
  input  logic link_up_chg,
  input  logic done_pulse,
  input  logic core_rst_n,
  output logic train_en
);
  hold_state_e state_q, state_d;
  logic        was_up_q, was_up_d;
  logic        arm;

  assign arm = enh_mode && dly_en && was_up_q && reset_evt;

  always_comb begin
    state_d  = state_q;
    was_up_d = was_up_q | link_up_chg;
    unique case (state_q)
      HOLD_RUN:  if (arm) state_d = HOLD_WAIT;
      HOLD_WAIT: if (!arm && done_pulse) state_d = HOLD_RUN;
      default:   state_d = HOLD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= HOLD_RUN;
      was_up_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      was_up_q <= was_up_d;
    end
  end

  assign train_en = core_rst_n && !(enh_mode && (state_q == HOLD_WAIT));

  a_r5_hold_arms: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (state_q == HOLD_WAIT));
  a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == HOLD_WAIT) && done_pulse && !reset_evt) |=> (state_q == HOLD_RUN));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == HOLD_RUN) && !reset_evt) |=> (state_q == HOLD_RUN));
  a_r7_no_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!was_up_q && (state_q == HOLD_RUN)) |=> (state_q == HOLD_RUN));
endmodule

// File: rtl/link_hold_ctrl.sv
module link_hold_ctrl
  import lhc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [11:0] CTRL_OFS = 12'h180,
  parameter logic [11:0] STAT_OFS = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst_n,
  input  logic              reset_evt,
  input  logic              link_up_chg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              train_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(STAT_OFS + 12'h004);

  logic [CTRL_W-1:0] ctrl_q;
  logic              done_pulse;
  logic [EVT_N-1:0]  status_q, mask_q, evt_set;
  logic              sel_ctrl, sel_stat, sel_mask;

  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_stat = (bus_addr == A_STAT);
  assign sel_mask = (bus_addr == A_MASK);

  assign evt_set[EVT_RST]  = reset_evt;
  assign evt_set[EVT_LINK] = link_up_chg;

  lhc_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_we && sel_ctrl),
    .wdata      (bus_wdata[2*CTRL_W-1:0]),
    .ctrl_q     (ctrl_q),
    .done_pulse (done_pulse)
  );

  lhc_irq #(.N(EVT_N)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_set   (evt_set),
    .clr_we    (bus_we && sel_stat),
    .clr_bits  (bus_wdata[EVT_N-1:0]),
    .mask_we   (bus_we && sel_mask),
    .mask_bits (bus_wdata[EVT_N-1:0]),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  lhc_hold_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enh_mode    (ctrl_q[BIT_ENH]),
    .dly_en      (ctrl_q[BIT_DLY_EN]),
    .reset_evt   (reset_evt),
    .link_up_chg (link_up_chg),
    .done_pulse  (done_pulse),
    .core_rst_n  (core_rst_n),
    .train_en    (train_en)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata[CTRL_W-1:0] = ctrl_q;
    else if (sel_stat) bus_rdata[EVT_N-1:0]  = status_q;
    else if (sel_mask) bus_rdata[EVT_N-1:0]  = mask_q;
  end

  a_r4_core_gates: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_n) |-> !train_en);
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ctrl && !sel_stat && !sel_mask) |-> (bus_rdata == '0));
endmodule

// File: tb/test_link_hold_ctrl.sv
module test_link_hold_ctrl;
  localparam logic [11:0] A_CTRL = 12'h180;
  localparam logic [11:0] A_STAT = 12'h010;
  localparam logic [11:0] A_MASK = 12'h014;
  localparam logic [11:0] A_NONE = 12'h044;

  logic        clk = 1'b0;
  logic        rst_n, core_rst_n, reset_evt, link_up_chg, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        train_en, irq;

  int unsigned n_run = 0, n_fail = 0, cyc = 0;

  logic [15:0] m_ctrl;
  logic [1:0]  m_st, m_mask;
  logic        m_hold, m_up;

  always #2ns clk = ~clk;

  link_hold_ctrl i_link_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .reset_evt(reset_evt),
    .link_up_chg(link_up_chg), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .train_en(train_en), .irq(irq)
  );

  function automatic logic exp_train(logic core);
    return core && !(m_ctrl[4] && m_hold);
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    if (a == A_CTRL) return {16'h0, m_ctrl};
    if (a == A_STAT) return {30'h0, m_st};
    if (a == A_MASK) return {30'h0, m_mask};
    return 32'h0;
  endfunction

  function automatic string rd_tag(logic [11:0] a);
    if (a == A_CTRL) return "R2";
    if (a == A_STAT) return "R10";
    if (a == A_MASK) return "R11";
    return "R12";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // drive at negedge, compare against model, advance model over the edge
  task automatic step(logic core, logic evt, logic lchg, logic we,
                      logic [11:0] a, logic [31:0] d);
    logic done;
    @(negedge clk);
    core_rst_n = core; reset_evt = evt; link_up_chg = lchg;
    bus_we = we; bus_addr = a; bus_wdata = d;
    #1ns;
    chk(!core ? "R4" : (m_ctrl[4] ? "R5" : "R8"), {31'h0, train_en}, {31'h0, exp_train(core)});
    chk(rd_tag(a), bus_rdata, exp_rd(a));
    chk("R11", {31'h0, irq}, {31'h0, |(m_st & m_mask)});
    done = we && (a == A_CTRL) && d[19] && d[3];
    if (m_ctrl[4] && m_ctrl[1] && m_up && evt) m_hold = 1'b1;
    else if (done)                              m_hold = 1'b0;
    m_up = m_up | lchg;
    if (we && a == A_STAT) m_st = m_st & ~d[1:0];
    m_st = m_st | {lchg, evt};
    if (we && a == A_MASK) m_mask = d[1:0];
    if (we && a == A_CTRL)
      for (int i = 0; i < 16; i++) if (d[16+i]) m_ctrl[i] = (i == 3) ? 1'b0 : d[i];
    @(posedge clk);
  endtask

  task automatic idle(logic core, logic [11:0] a);
    step(core, 1'b0, 1'b0, 1'b0, a, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; core_rst_n = 1'b1; reset_evt = 1'b0; link_up_chg = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ctrl = '0; m_st = '0; m_mask = '0; m_hold = 1'b0; m_up = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1ns;
    chk("R1", bus_rdata, 32'h0);
    chk("R1", {31'h0, train_en}, 32'h1);
    chk("R1", {31'h0, irq}, 32'h0);
    idle(1'b1, A_STAT);
    idle(1'b1, A_MASK);
    // R2 masked write: only bits 1 and 4 selected
    step(1'b1, 0, 0, 1, A_CTRL, 32'h0012_FFFF);
    idle(1'b1, A_CTRL);
    chk("R2", bus_rdata, 32'h0000_0012);
    // R7 reset event before link ever up: no hold
    step(1'b1, 1, 0, 0, A_NONE, 32'h0);
    idle(1'b1, A_STAT);
    chk("R7", {31'h0, train_en}, 32'h1);
    chk("R9", bus_rdata, 32'h1);
    // link up, then R4/R5 hold sequence
    step(1'b1, 0, 1, 0, A_NONE, 32'h0);
    idle(1'b1, A_STAT);
    chk("R9", bus_rdata, 32'h3);
    step(1'b0, 1, 0, 0, A_NONE, 32'h0);
    idle(1'b0, A_NONE);
    chk("R4", {31'h0, train_en}, 32'h0);
    idle(1'b1, A_NONE);
    chk("R5", {31'h0, train_en}, 32'h0);
    step(1'b1, 0, 0, 1, A_CTRL, 32'h0008_0008);
    idle(1'b1, A_CTRL);
    chk("R5", {31'h0, train_en}, 32'h1);
    chk("R3", bus_rdata, 32'h0000_0012);
    // R6 redundant done
    step(1'b1, 0, 0, 1, A_CTRL, 32'h0008_0008);
    idle(1'b1, A_NONE);
    chk("R6", {31'h0, train_en}, 32'h1);
    // R11 mask, R10 clear with set winning
    step(1'b1, 0, 0, 1, A_MASK, 32'h2);
    idle(1'b1, A_NONE);
    chk("R11", {31'h0, irq}, 32'h1);
    step(1'b1, 0, 1, 1, A_STAT, 32'h3);
    idle(1'b1, A_STAT);
    chk("R10", bus_rdata, 32'h2);
    step(1'b1, 0, 0, 1, A_STAT, 32'h2);
    idle(1'b1, A_NONE);
    chk("R11", {31'h0, irq}, 32'h0);
    // R8 delay off: event makes no hold
    step(1'b1, 0, 0, 1, A_CTRL, 32'h0002_0000);
    step(1'b1, 1, 0, 0, A_NONE, 32'h0);
    idle(1'b1, A_NONE);
    chk("R8", {31'h0, train_en}, 32'h1);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      int unsigned s = $urandom_range(0, 3);
      a = (s == 0) ? A_CTRL : (s == 1) ? A_STAT : (s == 2) ? A_MASK : A_NONE;
      d = $urandom();
      if (a == A_CTRL && $urandom_range(0, 3) == 0) d = 32'h0008_0008;
      step($urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) < 4, a, d);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule